// File: doc/BRIEF.md
# SDRAM Single-Burst Write Sequencer

This block drives the command, address, bank and data pins of a 16-bit mobile SDRAM for one write. A host raises a request with a bank, a row, a starting column, four data words and their byte masks. The block opens the row, issues a four-beat write burst with auto precharge disabled, waits out the write recovery time, closes the bank with an explicit precharge and then returns a one-cycle acknowledge once the precharge period has passed.

All command spacing comes from nanosecond parameters and the clock period given as parameters. Each wait is rounded up to whole cycles, with a floor of one cycle. The precharge goes out when two limits have both passed: the write recovery time after the last data beat, and the minimum row-active time after the activate. A new activate is held back until the row-cycle time since the previous one has passed. Clock enable stays high throughout.

Top module: `sdram_wr_seq`

## Requirements
- R1: After reset the pins show NOP (cs_n,ras_n,cas_n,we_n = 0111), dq_oe and ack are low, and cke is high in every cycle. A reset during a transaction abandons it and clears the row-cycle hold-off.
- R2: A request seen in idle, with no hold-off pending, gives ACTIVE (0111 becomes 0011) on the pins in the following cycle, with the row on addr and the bank on ba.
- R3: WRITE (0100) appears ceil(tRCD/tCK) cycles after ACTIVE. It carries the start column on addr[8:0], addr[10] low (no auto precharge) and every other addr bit low.
- R4: dq_oe is high for exactly four consecutive cycles, starting in the WRITE cycle. Beat k (k = 0..3) drives wdata[16k+15:16k] on dq and wmask[2k+1:2k] on dqm, where dqm bit 0 masks the low byte and bit 1 masks the high byte.
- R5: During beat k, addr shows the column start+k modulo 512.
- R6: PRECHARGE (0010) appears max(tRCD_c+3+tWR_c, tRAS_c) cycles after ACTIVE, where _c means rounded up to cycles. ba names the bank, and addr[10] is high for the all-banks form and low for the single-bank form, with all other addr bits low.
- R7: ack is high for exactly one cycle, ceil(tRP/tCK) cycles after PRECHARGE.
- R8: The next ACTIVE comes no earlier than ceil(tRC/tCK) cycles after the previous ACTIVE, and no earlier than the cycle after ack. If the request is held high it is accepted at the first cycle that meets both limits.
- R9: Every other cycle of a transaction carries NOP.
- R10: All request fields are captured when the request is accepted. Changes on those inputs afterwards do not affect the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Write request, sampled in idle |
| bank_i | input | 2 | Target bank |
| row_i | input | 13 | Row to open |
| col_i | input | 9 | Starting column |
| wdata_i | input | 64 | Four data words, beat 0 in the low 16 bits |
| wmask_i | input | 8 | Byte masks, two bits per beat, beat 0 lowest |
| pre_all_i | input | 1 | 1 selects the all-banks precharge |
| ack_o | output | 1 | One-cycle completion pulse |
| cke_o | output | 1 | Clock enable, held high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Row / column / precharge-mode address |
| dq_o | output | 16 | Write data |
| dq_oe_o | output | 1 | Data output enable |
| dqm_o | output | 2 | Byte masks for the current beat |

## Verification
With the default 5 ns timing, two limits run out in the same cycle at offset 10 after ACTIVE: the write-recovery wait after the last beat and the minimum row-active time. A single PRECHARGE must go out there, neither early nor twice. A second pair also meets in one place: the acknowledge at offset 14 and the row-cycle limit at offset 16. The bench holds the request high straight through the acknowledge and requires the next ACTIVE to appear exactly at offset 16, with NOP at offset 15.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    // Pin command on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_BURST,
        ST_RECOV,
        ST_CLOSE
    } seq_st_e;

    // Round a time up to whole clock cycles, never below one
    function automatic int ns2cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_act_timer.sv
// Saturating count of cycles since the last ACTIVE left the pins.
module sdram_act_timer #(
    parameter int CNT_MAX = 32,
    parameter int CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [CNT_W-1:0] elapsed_n
);
    logic [CNT_W-1:0] cnt;

    assign elapsed_n = (cnt == CNT_W'(CNT_MAX)) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)        cnt <= CNT_W'(CNT_MAX);
        else if (start) cnt <= '0;
        else            cnt <= elapsed_n;
    end
endmodule

// File: rtl/sdram_beat_sel.sv
// Picks the word, byte masks and column for one burst beat.
module sdram_beat_sel #(
    parameter int BEATS  = 4,
    parameter int DQ_W   = 16,
    parameter int MASK_W = 2,
    parameter int COL_W  = 9,
    parameter int BEAT_W = 2
) (
    input  logic [BEATS*DQ_W-1:0]   data,
    input  logic [BEATS*MASK_W-1:0] mask,
    input  logic [COL_W-1:0]        col,
    input  logic [BEAT_W-1:0]       idx,
    output logic [DQ_W-1:0]         word,
    output logic [MASK_W-1:0]       bmask,
    output logic [COL_W-1:0]        col_k
);
    logic [DQ_W-1:0]   lane_d [BEATS];
    logic [MASK_W-1:0] lane_m [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        assign lane_d[g] = data[g*DQ_W +: DQ_W];
        assign lane_m[g] = mask[g*MASK_W +: MASK_W];
    end

    assign word  = lane_d[idx];
    assign bmask = lane_m[idx];
    assign col_k = col + COL_W'(idx);
endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdram_wr_pkg::*;
#(
    parameter int CLK_NS   = 5,
    parameter int T_RCD_NS = 20,
    parameter int T_RAS_NS = 48,
    parameter int T_RC_NS  = 80,
    parameter int T_RP_NS  = 20,
    parameter int T_WR_NS  = 15,
    parameter int ROW_W    = 13,
    parameter int COL_W    = 9,
    parameter int BANK_W   = 2,
    parameter int DQ_W     = 16,
    parameter int BEATS    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_i,
    input  logic [BANK_W-1:0]           bank_i,
    input  logic [ROW_W-1:0]            row_i,
    input  logic [COL_W-1:0]            col_i,
    input  logic [BEATS*DQ_W-1:0]       wdata_i,
    input  logic [BEATS*(DQ_W/8)-1:0]   wmask_i,
    input  logic                        pre_all_i,
    output logic                        ack_o,
    output logic                        cke_o,
    output logic                        cs_n_o,
    output logic                        ras_n_o,
    output logic                        cas_n_o,
    output logic                        we_n_o,
    output logic [BANK_W-1:0]           ba_o,
    output logic [ROW_W-1:0]            addr_o,
    output logic [DQ_W-1:0]             dq_o,
    output logic                        dq_oe_o,
    output logic [DQ_W/8-1:0]           dqm_o
);
    localparam int MASK_W  = DQ_W / 8;
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int AP_BIT  = 10;
    localparam int RCD_C   = ns2cyc(T_RCD_NS, CLK_NS);
    localparam int RAS_C   = ns2cyc(T_RAS_NS, CLK_NS);
    localparam int RC_C    = ns2cyc(T_RC_NS,  CLK_NS);
    localparam int RP_C    = ns2cyc(T_RP_NS,  CLK_NS);
    localparam int WR_C    = ns2cyc(T_WR_NS,  CLK_NS);
    localparam int LAST_T  = RCD_C + BEATS - 1;
    localparam int PRE_T   = imax(LAST_T + WR_C, RAS_C);
    localparam int ACK_T   = PRE_T + RP_C;
    localparam int CNT_MAX = imax(RC_C, ACK_T) + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_st_e                   st;
    sdr_cmd_e                  cmd_q;
    logic [BANK_W-1:0]         bank_r;
    logic [ROW_W-1:0]          row_r;
    logic [COL_W-1:0]          col_r;
    logic [BEATS*DQ_W-1:0]     data_r;
    logic [BEATS*MASK_W-1:0]   mask_r;
    logic                      all_r;
    logic [BEAT_W-1:0]         beat_r;
    logic [CNT_W-1:0]          elapsed_n;
    logic                      accept;
    logic [DQ_W-1:0]           beat_word;
    logic [MASK_W-1:0]         beat_mask;
    logic [COL_W-1:0]          beat_col;
    logic [ROW_W-1:0]          col_addr;
    logic [ROW_W-1:0]          pre_addr;

    assign accept = (st == ST_IDLE) && req_i && (elapsed_n >= CNT_W'(RC_C));

    sdram_act_timer #(
        .CNT_MAX (CNT_MAX),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .elapsed_n (elapsed_n)
    );

    sdram_beat_sel #(
        .BEATS  (BEATS),
        .DQ_W   (DQ_W),
        .MASK_W (MASK_W),
        .COL_W  (COL_W),
        .BEAT_W (BEAT_W)
    ) u_beat (
        .data  (data_r),
        .mask  (mask_r),
        .col   (col_r),
        .idx   (beat_r),
        .word  (beat_word),
        .bmask (beat_mask),
        .col_k (beat_col)
    );

    // Column sits below the auto-precharge bit, which stays low
    assign col_addr = ROW_W'(beat_col);
    assign pre_addr = ROW_W'(all_r) << AP_BIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cmd_q   <= CMD_NOP;
            ba_o    <= '0;
            addr_o  <= '0;
            dq_o    <= '0;
            dqm_o   <= '0;
            dq_oe_o <= 1'b0;
            ack_o   <= 1'b0;
            bank_r  <= '0;
            row_r   <= '0;
            col_r   <= '0;
            data_r  <= '0;
            mask_r  <= '0;
            all_r   <= 1'b0;
            beat_r  <= '0;
        end else begin
            cmd_q   <= CMD_NOP;
            ba_o    <= '0;
            addr_o  <= '0;
            dq_o    <= '0;
            dqm_o   <= '0;
            dq_oe_o <= 1'b0;
            ack_o   <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        bank_r <= bank_i;
                        row_r  <= row_i;
                        col_r  <= col_i;
                        data_r <= wdata_i;
                        mask_r <= wmask_i;
                        all_r  <= pre_all_i;
                        beat_r <= '0;
                        cmd_q  <= CMD_ACT;
                        ba_o   <= bank_i;
                        addr_o <= row_i;
                        st     <= ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    ba_o <= bank_r;
                    if (elapsed_n == CNT_W'(RCD_C)) begin
                        cmd_q   <= CMD_WR;
                        addr_o  <= col_addr;
                        dq_o    <= beat_word;
                        dqm_o   <= beat_mask;
                        dq_oe_o <= 1'b1;
                        beat_r  <= beat_r + 1'b1;
                        st      <= ST_BURST;
                    end
                end
                ST_BURST: begin
                    ba_o    <= bank_r;
                    addr_o  <= col_addr;
                    dq_o    <= beat_word;
                    dqm_o   <= beat_mask;
                    dq_oe_o <= 1'b1;
                    beat_r  <= beat_r + 1'b1;
                    if (beat_r == BEAT_W'(BEATS - 1)) st <= ST_RECOV;
                end
                ST_RECOV: begin
                    if (elapsed_n == CNT_W'(PRE_T)) begin
                        cmd_q  <= CMD_PRE;
                        ba_o   <= bank_r;
                        addr_o <= pre_addr;
                        st     <= ST_CLOSE;
                    end
                end
                ST_CLOSE: begin
                    if (elapsed_n == CNT_W'(ACK_T)) begin
                        ack_o <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cke_o = 1'b1;
    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;

endmodule

// File: rtl/sdram_wr_seq_chk.sv
module sdram_wr_seq_chk
    import sdram_wr_pkg::*;
#(
    parameter int RCD   = 4,
    parameter int RAS   = 10,
    parameter int RC    = 16,
    parameter int CNT_W = 5,
    parameter int ROW_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic             ack,
    input logic [ROW_W-1:0] addr
);
    logic [3:0]       cmd;
    logic [CNT_W-1:0] since;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    // Cycles since the previous ACTIVE on the pins, saturating
    always_ff @(posedge clk) begin
        if (rst)                    since <= '1;
        else if (cmd == CMD_ACT)    since <= CNT_W'(1);
        else if (since != '1)       since <= since + 1'b1;
    end

    assert_wr_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WR) |-> (since == CNT_W'(RCD)));

    assert_wr_no_autopre_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WR) |-> (addr[10] == 1'b0));

    assert_oe_starts_on_write_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> (cmd == CMD_WR));

    assert_pre_after_ras_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> (since >= CNT_W'(RAS)));

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_act_spacing_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |-> (since >= CNT_W'(RC)));

endmodule

bind sdram_wr_seq sdram_wr_seq_chk #(
    .RCD   (RCD_C),
    .RAS   (RAS_C),
    .RC    (RC_C),
    .CNT_W (CNT_W),
    .ROW_W (ROW_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n_o),
    .ras_n (ras_n_o),
    .cas_n (cas_n_o),
    .we_n  (we_n_o),
    .dq_oe (dq_oe_o),
    .ack   (ack_o),
    .addr  (addr_o)
);

// File: tb/sdram_wr_seq_test.sv
module sdram_wr_seq_test;

    localparam int TCK  = 5;
    localparam int RCDN = 20, RASN = 48, RCN = 80, RPN = 20, WRN = 15;

    function automatic int up(input int t);
        int c;
        c = t / TCK;
        if (c * TCK < t) c++;
        if (c < 1) c = 1;
        return c;
    endfunction

    localparam int E_RCD = up(RCDN);
    localparam int E_WR  = up(WRN);
    localparam int E_RAS = up(RASN);
    localparam int E_RP  = up(RPN);
    localparam int E_RC  = up(RCN);
    localparam int E_PRE = (E_RCD + 3 + E_WR > E_RAS) ? E_RCD + 3 + E_WR : E_RAS;
    localparam int E_ACK = E_PRE + E_RP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [1:0]  bank_i = '0;
    logic [12:0] row_i = '0;
    logic [8:0]  col_i = '0;
    logic [63:0] wdata_i = '0;
    logic [7:0]  wmask_i = '0;
    logic        pre_all_i = 1'b0;
    logic        ack_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, dq_oe_o;
    logic [1:0]  ba_o, dqm_o;
    logic [12:0] addr_o;
    logic [15:0] dq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    sdram_wr_seq #(
        .CLK_NS(TCK), .T_RCD_NS(RCDN), .T_RAS_NS(RASN),
        .T_RC_NS(RCN), .T_RP_NS(RPN), .T_WR_NS(WRN)
    ) uut (
        .clk(clk), .rst(rst), .req_i(req_i), .bank_i(bank_i), .row_i(row_i),
        .col_i(col_i), .wdata_i(wdata_i), .wmask_i(wmask_i), .pre_all_i(pre_all_i),
        .ack_o(ack_o), .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
        .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dqm_o(dqm_o)
    );

    function automatic logic [3:0] pins();
        return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One transaction; entered just after a negedge, leaves at the ack negedge.
    task automatic txn(input logic [1:0] b, input logic [12:0] r, input logic [8:0] c,
                       input logic [63:0] d, input logic [7:0] m, input logic all,
                       input int exp_delay, input logic scramble);
        int n;
        bank_i = b; row_i = r; col_i = c; wdata_i = d; wmask_i = m; pre_all_i = all;
        req_i = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pins() != 4'b0011 && n < 60);
        chk("R8 activate delay after request", n, exp_delay);
        req_i = 1'b0;
        if (scramble) begin   // R10: inputs change after acceptance
            bank_i = ~b; row_i = ~r; col_i = ~c; wdata_i = ~d; wmask_i = ~m; pre_all_i = ~all;
        end
        for (int k = 0; k <= E_ACK; k++) begin
            logic [3:0] ec;
            logic       eoe;
            if (k > 0) @(negedge clk);
            ec  = (k == 0) ? 4'b0011 : (k == E_RCD) ? 4'b0100 :
                  (k == E_PRE) ? 4'b0010 : 4'b0111;
            eoe = (k >= E_RCD) && (k <= E_RCD + 3);
            chk(k == 0 ? "R2 command" : k == E_RCD ? "R3 command" :
                k == E_PRE ? "R6 command" : "R9 command", pins(), ec);
            chk("R1 cke", cke_o, 1'b1);
            chk("R4 dq_oe", dq_oe_o, eoe);
            chk("R7 ack", ack_o, k == E_ACK);
            if (k == 0) begin
                chk("R2 row", addr_o, r);
                chk("R2 bank", ba_o, b);
            end
            if (eoe) begin
                chk("R4 data R10", dq_o, d[16*(k-E_RCD) +: 16]);
                chk("R4 mask", dqm_o, m[2*(k-E_RCD) +: 2]);
                chk(k == E_RCD ? "R3 column addr" : "R5 column addr",
                    addr_o, {4'b0000, c + 9'(k - E_RCD)});
            end
            if (k == E_PRE) begin
                chk("R6 bank", ba_o, b);
                chk("R6 addr", addr_o, 13'(all) << 10);
            end
        end
    endtask

    task automatic t_reset;
        chk("R1 reset command", pins(), 4'b0111);
        chk("R1 reset oe", dq_oe_o, 1'b0);
        chk("R1 reset ack", ack_o, 1'b0);
        chk("R1 reset cke", cke_o, 1'b1);
    endtask

    task automatic t_single;
        txn(2'd1, 13'h1abc, 9'h040, 64'h4444_3333_2222_1111, 8'b00_01_10_00, 1'b0, 1, 1'b1);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_all_wrap;
        txn(2'd3, 13'h0005, 9'h1fe, 64'hdead_beef_cafe_f00d, 8'b11_00_01_10, 1'b1, 1, 1'b0);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_back_to_back;
        txn(2'd0, 13'h1fff, 9'h000, 64'h0123_4567_89ab_cdef, 8'h00, 1'b0, 1, 1'b0);
        // request held right through the ack; row-cycle limit sets the next ACTIVE
        txn(2'd2, 13'h0aaa, 9'h155, 64'hffff_0000_a5a5_5a5a, 8'hff, 1'b1, E_RC - E_ACK, 1'b1);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset_mid;
        bank_i = 2'd1; row_i = 13'h0123; col_i = 9'h010; wdata_i = 64'h1; wmask_i = 8'h0;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (E_RCD + 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid command", pins(), 4'b0111);
        chk("R1 reset mid oe", dq_oe_o, 1'b0);
        rst = 1'b0;
        // hold-off cleared by reset: next request goes out at once
        txn(2'd2, 13'h0777, 9'h0f0, 64'h0f0f_f0f0_3c3c_c3c3, 8'b01_10_11_00, 1'b0, 1, 1'b0);
        repeat (20) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_all_wrap();
        t_back_to_back();
        t_reset_mid();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        finish_run();
    end

endmodule